// File: doc/BRIEF.md
# Playback DMA Transfer Counter with Terminal-Count Interrupt

This block tracks how many bytes a DMA engine has delivered to a playback channel and raises an interrupt once a programmed block has been consumed. Software loads a 16-bit block count as two bytes. The block scales that count by the number of bytes each sample frame takes, so the count is in frames and the hardware compares bytes. The scale factor comes from the sample-format byte: sample width, mono or stereo, and whether the extended format field is active.

The block holds a DMA request level high while playback runs. It drops the request when playback is switched off, or when the format byte names a reserved encoding or an unsupported rate. Each DMA acknowledge pulse stands for one transferred byte. The interrupt flag stays set until the register block sends a clear pulse.

Top module: `pb_dma_counter`

## Requirements
- R1: After reset, `dma_req` and `irq` are 0.
- R2: The format code is `fmt[7:5]` when `ext_mode` is 1. It is `{0, fmt[6:5]}` when `ext_mode` is 0, so `fmt[7]` is ignored in that mode.
- R3: The byte shift is `wide + fmt[4]`. `wide` is 1 for codes 2 and 6 (16-bit samples) and 0 for codes 0, 1 and 3 (8-bit samples). `fmt[4]` = 1 selects stereo.
- R4: Codes 4, 5 and 7 set `fmt_err`. While `fmt_err` is 1, `dma_req` is 0 in the following cycle.
- R5: `fmt_err` is also set when `fmt[0]` = 0 and `fmt[3:1]` is 4 or 5 (an unsupported rate).
- R6: `dma_req` goes to 1 on the clock edge after `play_en` rises, provided the format is valid. It goes to 0 on the edge after `play_en` falls.
- R7: The terminal count is `{base_hi, base_lo} << shift`. The acknowledge that brings the byte count up to that value sets `irq` on the same edge and returns the count to 0.
- R8: While `irq_en` is 0, acknowledges neither advance the count nor set `irq`. The count already reached is kept.
- R9: A rising edge on `play_en` clears the byte count.
- R10: `irq` stays at 1 until an `irq_clr` pulse. A hit that falls on the same edge as a clear takes priority, so `irq` stays set.
- R11: Acknowledges that arrive while `dma_req` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt | input | 8 | Playback format byte: rate, clock source, stereo and code |
| ext_mode | input | 1 | Selects the 3-bit format code field |
| base_hi | input | 8 | Upper byte of the block count |
| base_lo | input | 8 | Lower byte of the block count |
| play_en | input | 1 | Playback enable |
| irq_en | input | 1 | Counting and interrupt enable |
| dma_ack | input | 1 | One pulse per byte transferred |
| irq_clr | input | 1 | Clear pulse for the interrupt flag |
| dma_req | output | 1 | DMA request level |
| irq | output | 1 | Terminal-count interrupt flag |
| fmt_err | output | 1 | Reserved format or unsupported rate |

## Verification
The bench sweeps every format byte in both field modes and counts the acknowledges each one needs before `irq` appears. A wrong shift therefore shows up as an interrupt that comes twice or half as early. Reading bit 7 in the wrong mode, or missing a reserved rate, shows up as a request level that does not match the model's prediction. Directed cases then address the following:
- A counter that keeps advancing with the interrupt disabled would fire early once the interrupt is enabled.
- A count that survives a playback restart would interrupt too soon.
- A large two-byte count exposes a dropped upper byte, or a terminal count too narrow to hold the shifted value.

// File: rtl/pb_dma_counter.sv
module pb_dma_counter #(
  parameter int CNT_W     = 16,
  parameter int MAX_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       fmt,
  input  logic             ext_mode,
  input  logic [CNT_W/2-1:0] base_hi,
  input  logic [CNT_W/2-1:0] base_lo,
  input  logic             play_en,
  input  logic             irq_en,
  input  logic             dma_ack,
  input  logic             irq_clr,
  output logic             dma_req,
  output logic             irq,
  output logic             fmt_err
);
  localparam int TERM_W = CNT_W + MAX_SHIFT;

  logic [2:0]        code;
  logic              code_bad, rate_bad, wide;
  logic [1:0]        shift;
  logic [TERM_W-1:0] term, cnt;
  logic              en_q, start, take, hit;

  assign code     = ext_mode ? fmt[7:5] : {1'b0, fmt[6:5]};
  assign code_bad = (code == 3'd4) || (code == 3'd5) || (code == 3'd7);
  assign rate_bad = !fmt[0] && ((fmt[3:1] == 3'd4) || (fmt[3:1] == 3'd5));
  assign fmt_err  = code_bad || rate_bad;
  assign wide     = (code == 3'd2) || (code == 3'd6);
  assign shift    = {1'b0, wide} + {1'b0, fmt[4]};
  assign term     = TERM_W'({base_hi, base_lo}) << shift;

  assign start = play_en && !en_q;
  assign take  = dma_req && dma_ack && irq_en;
  assign hit   = take && (({1'b0, cnt} + 1'b1) == {1'b0, term});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      dma_req <= 1'b0;
      cnt     <= '0;
      irq     <= 1'b0;
    end else begin
      en_q    <= play_en;
      dma_req <= play_en && !fmt_err && (dma_req || start);
      if (start)     cnt <= '0;
      else if (hit)  cnt <= '0;
      else if (take) cnt <= cnt + 1'b1;
      if (hit)          irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

module pb_dma_counter_chk (
  input logic clk,
  input logic rst_n,
  input logic play_en,
  input logic irq_en,
  input logic dma_ack,
  input logic irq_clr,
  input logic fmt_err,
  input logic dma_req,
  input logic irq
);
  // R6
  req_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> !dma_req);
  // R4
  bad_fmt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> !dma_req);
  // R10
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  // R8
  no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !irq_en |=> !irq);
  // R11
  no_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !(dma_req && dma_ack) |=> !irq);
endmodule

bind pb_dma_counter pb_dma_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .play_en(play_en), .irq_en(irq_en),
  .dma_ack(dma_ack), .irq_clr(irq_clr), .fmt_err(fmt_err),
  .dma_req(dma_req), .irq(irq)
);

// File: tb/test_pb_dma_counter.sv
module test_pb_dma_counter;
  logic clk = 0, rst_n = 0;
  logic [7:0] fmt = 0, base_hi = 0, base_lo = 0;
  logic ext_mode = 0, play_en = 0, irq_en = 0, dma_ack = 0, irq_clr = 0;
  logic dma_req, irq, fmt_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pb_dma_counter i_pb_dma_counter (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (fmt=%02h ext=%0d)", req, act, exp, fmt, ext_mode);
    end
  endtask

  function automatic int m_code(input logic [7:0] f, input logic e);
    return e ? int'(f[7:5]) : int'(f[6:5]);
  endfunction
  function automatic bit m_err(input logic [7:0] f, input logic e);
    int c = m_code(f, e);
    return (c == 4 || c == 5 || c == 7) || (!f[0] && (f[3:1] == 4 || f[3:1] == 5));
  endfunction
  function automatic int m_shift(input logic [7:0] f, input logic e);
    int c = m_code(f, e);
    return ((c == 2 || c == 6) ? 1 : 0) + int'(f[4]);
  endfunction

  task automatic run_to_irq(input int limit, output int n);
    n = 0;
    dma_ack = 1;
    while (n < limit) begin
      tick; n++;
      if (irq) break;
    end
    dma_ack = 0;
  endtask

  task automatic clear_irq; irq_clr = 1; tick; irq_clr = 0; endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    #12 rst_n = 1; tick;
    chk("R1 dma_req", dma_req, 0);
    chk("R1 irq", irq, 0);

    // R2 R3 R4 R5 R6 R7 sweep
    for (int e = 0; e < 2; e++)
      for (int f = 0; f < 256; f++) begin
        fmt = 8'(f); ext_mode = e[0]; base_hi = 0; base_lo = 3; irq_en = 1;
        #1 chk("R4/R5 fmt_err", fmt_err, m_err(fmt, ext_mode));
        play_en = 1; tick;
        chk("R2/R4/R6 dma_req", dma_req, !m_err(fmt, ext_mode));
        if (!m_err(fmt, ext_mode)) begin
          run_to_irq(20, n);
          chk("R3/R7 acks", n, 3 << m_shift(fmt, ext_mode));
          clear_irq;
        end
        play_en = 0; tick;
        chk("R6 release", dma_req, 0);
      end

    fmt = 8'h00; ext_mode = 0; base_hi = 0; base_lo = 3;
    // R11 ack before request
    irq_en = 1; dma_ack = 1; tick; tick; tick; dma_ack = 0;
    play_en = 1; tick;
    run_to_irq(20, n);
    chk("R11 acks", n, 3);
    // R10 holds, then clears
    tick; tick;
    chk("R10 held", irq, 1);
    clear_irq;
    chk("R10 cleared", irq, 0);
    // R7 counter restarts after hit
    run_to_irq(20, n);
    chk("R7 second block", n, 3);
    clear_irq;
    // R8 disabled counting
    irq_en = 0; dma_ack = 1;
    for (int i = 0; i < 20; i++) tick;
    dma_ack = 0;
    chk("R8 no irq", irq, 0);
    irq_en = 1;
    run_to_irq(20, n);
    chk("R8 count held", n, 3);
    clear_irq;
    // R8 partial count kept across disable
    dma_ack = 1; tick; dma_ack = 0; irq_en = 0; tick; irq_en = 1;
    run_to_irq(20, n);
    chk("R8 partial kept", n, 2);
    clear_irq;
    // R9 restart clears partial count
    dma_ack = 1; tick; tick; dma_ack = 0;
    play_en = 0; tick; play_en = 1; tick;
    run_to_irq(20, n);
    chk("R9 restart", n, 3);
    clear_irq;
    play_en = 0; tick;
    // R7 large two-byte count, 16-bit stereo
    fmt = 8'h50; base_hi = 8'h01; base_lo = 8'h02;
    play_en = 1; tick;
    run_to_irq(1100, n);
    chk("R7 large", n, 258 << 2);
    // R10 hit beats clear
    clear_irq; base_hi = 0; base_lo = 1; fmt = 8'h00;
    dma_ack = 1; irq_clr = 1; tick; dma_ack = 0; irq_clr = 0;
    chk("R10 hit wins", irq, 1);
    clear_irq;
    // R4 error while running drops request
    fmt = 8'h80; ext_mode = 1; tick;
    chk("R4 running", dma_req, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule